// File: doc/BRIEF.md
# Serial display pixel packer

This block sits between a framebuffer reader and the serial shifter of a small display controller link. During a memory-write burst it accepts 24-bit pixels (red in bits 23:16, green in 15:8, blue in 7:0) with a valid/ready handshake and an end-of-burst flag. It emits the bytes that go on the wire, most significant byte first, through a byte-wide valid/ready handshake with a matching end-of-burst flag on the final byte.

A wire-format select and a colour-order select choose the output layout. The block supports 16-bit 5-6-5 words, 18-bit colour carried as three bytes, full 8-bit colour as three bytes, and two 3-bit layouts that hold two pixels per byte. Components are narrowed by keeping their most significant bits. Bits the receiver ignores are driven as zero. The colour-order select swaps red and blue and leaves green in place.

Both selects are copied into a held configuration on every idle cycle between bursts. A burst is packed entirely with the configuration that was held when its first pixel was accepted. The selects should therefore be settled at least one cycle before a burst starts.

Top module: `pix_wire_packer`

## Requirements
- R1: Out of reset the output is idle (out_valid 0, in_ready 1). The held configuration is the 16-bit 5-6-5 layout in RGB order, so a pixel accepted on the first clock edge after reset is packed that way, whatever fmt_sel shows.
- R2: fmt_sel = 0 selects 5-6-5: two bytes per pixel, forming the word {R[7:3], G[7:2], B[7:3]}, with the high byte sent first. The unused codes 5, 6 and 7 behave the same way.
- R3: fmt_sel = 1 selects 6-6-6: three bytes per pixel, in the order first colour, green, last colour. Each byte is {C[7:2], 2'b00}.
- R4: bgr_sel = 1 exchanges red and blue in every layout. Green keeps its position.
- R5: fmt_sel = 3 selects packed 3-bit mode: each byte is {2'b00, P0, P1}, where P0 is the earlier pixel in bits 5:3 and each 3-bit pixel is {R[7], G[7], B[7]} (in RGB order).
- R6: fmt_sel = 4 selects nibble 3-bit mode: each byte is {1'b0, P0, 1'b0, P1}, with the earlier pixel in bits 6:4.
- R7: In either 3-bit mode, a burst with an odd pixel count ends with one extra byte whose second pixel slot is zero.
- R8: fmt_sel = 2 sends the full 8 bits of each colour as three bytes. With bgr_sel = 1 the order is blue, green, red.
- R9: Changes to fmt_sel or bgr_sel after the first pixel of a burst is accepted do not affect that burst.
- R10: in_ready stays low while any byte of an earlier pixel is still pending. A byte offered with out_ready low stays unchanged until it is taken.
- R11: out_last is high on exactly the final byte of each burst and on no other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 3 | Wire format code |
| bgr_sel | input | 1 | 1 swaps red and blue |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel can be taken |
| in_pix | input | 24 | Pixel {R, G, B} |
| in_last | input | 1 | Last pixel of burst |
| out_valid | output | 1 | Byte offered |
| out_ready | input | 1 | Byte taken |
| out_byte | output | 8 | Wire byte |
| out_last | output | 1 | Final byte of burst |

## Verification
The hardest situation to reach from the ports is a configuration change that arrives while a two-pixels-per-byte burst has half a byte parked inside the block. Nothing at the outputs shows that a pixel is being held. The stimulus starts a 3-bit burst, changes both selects after an odd number of pixels, and then completes the burst. The bytes that follow must still use the original layout and colour order. A second hard case is the reset default, which only shows if a pixel is accepted on the very first edge after reset while fmt_sel already requests another layout. The bench releases reset and presents such a pixel in the same half cycle.

// File: rtl/pwp_pkg.sv
// Package: widths and format codes shared by the pixel packer.
// Assumes one byte lane equals one colour component width.
package pwp_pkg;
    localparam int COMP_W    = 8;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 3;
    localparam int PIX_W     = 3 * COMP_W;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int FMT_W     = 3;
    localparam int TRI_W     = 3;

    typedef enum logic [FMT_W-1:0] {
        FMT_RGB565     = 3'd0,
        FMT_RGB666     = 3'd1,
        FMT_FULL888    = 3'd2,
        FMT_TRI_PACKED = 3'd3,
        FMT_TRI_NIBBLE = 3'd4
    } wire_fmt_e;
endpackage

// File: rtl/pwp_cfg_hold.sv
// Module: holds the format and colour-order selects for the duration of a burst.
// Assumes: the selects are copied on idle cycles only; the held value is used by the datapath.
module pwp_cfg_hold
    import pwp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FMT_W-1:0] fmt_sel,
    input  logic             bgr_sel,
    input  logic             accept,
    input  logic             accept_last,
    output logic [FMT_W-1:0] cfg_fmt,
    output logic             cfg_bgr,
    output logic             burst_active
);
    logic [FMT_W-1:0] fmt_q;
    logic             bgr_q;
    logic             burst_q;

    // Purpose: track burst membership and refresh the held selects between bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q   <= FMT_RGB565;
            bgr_q   <= 1'b0;
            burst_q <= 1'b0;
        end else begin
            if (accept) begin
                burst_q <= !accept_last;
            end
            if (!burst_q && !accept) begin
                fmt_q <= fmt_sel;
                bgr_q <= bgr_sel;
            end
        end
    end

    assign cfg_fmt      = fmt_q;
    assign cfg_bgr      = bgr_q;
    assign burst_active = burst_q;
endmodule

// File: rtl/pwp_pixel_format.sv
// Module: turns one pixel into up to MAX_BYTES wire bytes for the held format.
// Assumes: accept marks a pixel being taken; 3-bit modes park the first pixel of a pair.
module pwp_pixel_format
    import pwp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        accept,
    input  logic [PIX_W-1:0]            pix,
    input  logic                        last,
    input  logic [FMT_W-1:0]            fmt,
    input  logic                        bgr,
    output logic [MAX_BYTES*BYTE_W-1:0] bytes,
    output logic [CNT_W-1:0]            nbytes
);
    localparam int W5 = 5;
    localparam int W6 = 6;

    logic [COMP_W-1:0] red, grn, blu, c_first, c_last;
    logic [TRI_W-1:0]  tri_now, half_bits;
    logic              half_v;
    logic              is_tri;
    logic [BYTE_W-1:0] tri_byte;
    logic [2*BYTE_W-1:0] w565;

    assign red = pix[3*COMP_W-1 -: COMP_W];
    assign grn = pix[2*COMP_W-1 -: COMP_W];
    assign blu = pix[COMP_W-1 -: COMP_W];

    // Purpose: choose which of red/blue leads on the wire.
    always_comb begin
        c_first = bgr ? blu : red;
        c_last  = bgr ? red : blu;
    end

    assign tri_now = {c_first[COMP_W-1], grn[COMP_W-1], c_last[COMP_W-1]};
    assign is_tri  = (fmt == FMT_TRI_PACKED) || (fmt == FMT_TRI_NIBBLE);
    assign w565    = {c_first[COMP_W-1 -: W5], grn[COMP_W-1 -: W6], c_last[COMP_W-1 -: W5]};

    // Purpose: place a pair of 3-bit pixels into one byte for the active 3-bit layout.
    always_comb begin
        logic [TRI_W-1:0] p0, p1;
        if (half_v) begin
            p0 = half_bits;
            p1 = tri_now;
        end else begin
            p0 = tri_now;
            p1 = '0;
        end
        if (fmt == FMT_TRI_NIBBLE) tri_byte = {1'b0, p0, 1'b0, p1};
        else                       tri_byte = {2'b00, p0, p1};
    end

    // Purpose: build the byte lanes and their count for the held format.
    always_comb begin
        bytes  = '0;
        nbytes = '0;
        case (fmt)
            FMT_RGB666: begin
                bytes  = {c_first[COMP_W-1 -: W6], {(BYTE_W-W6){1'b0}},
                          grn[COMP_W-1 -: W6],     {(BYTE_W-W6){1'b0}},
                          c_last[COMP_W-1 -: W6],  {(BYTE_W-W6){1'b0}}};
                nbytes = CNT_W'(3);
            end
            FMT_FULL888: begin
                bytes  = {c_first, grn, c_last};
                nbytes = CNT_W'(3);
            end
            FMT_TRI_PACKED, FMT_TRI_NIBBLE: begin
                bytes  = {tri_byte, {(2*BYTE_W){1'b0}}};
                nbytes = (half_v || last) ? CNT_W'(1) : CNT_W'(0);
            end
            default: begin
                bytes  = {w565, {BYTE_W{1'b0}}};
                nbytes = CNT_W'(2);
            end
        endcase
    end

    // Purpose: park or release the first pixel of a 3-bit pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_v    <= 1'b0;
            half_bits <= '0;
        end else if (accept && is_tri) begin
            if (half_v) begin
                half_v <= 1'b0;
            end else if (!last) begin
                half_v    <= 1'b1;
                half_bits <= tri_now;
            end
        end
    end
endmodule

// File: rtl/pwp_byte_queue.sv
// Module: holds the bytes of one pixel and shifts them out first lane first.
// Assumes: load happens only while empty; a load with count zero leaves it empty.
module pwp_byte_queue
    import pwp_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [MAX_BYTES*BYTE_W-1:0] load_bytes,
    input  logic [CNT_W-1:0]            load_n,
    input  logic                        load_last,
    input  logic                        out_ready,
    output logic                        out_valid,
    output logic [BYTE_W-1:0]           out_byte,
    output logic                        out_last,
    output logic                        empty
);
    logic [BYTE_W-1:0] lane       [MAX_BYTES];
    logic [BYTE_W-1:0] lane_shift [MAX_BYTES];
    logic [CNT_W-1:0]  cnt;
    logic              last_q;
    logic              pop;

    assign pop = out_valid && out_ready;

    // Purpose: each lane takes its neighbour's byte on a pop; the tail fills with zero.
    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
        if (i < MAX_BYTES - 1) begin : g_mid
            assign lane_shift[i] = lane[i+1];
        end else begin : g_tail
            assign lane_shift[i] = '0;
        end
    end

    // Purpose: load a new pixel's bytes or advance by one byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_BYTES; i++) lane[i] <= '0;
            cnt    <= '0;
            last_q <= 1'b0;
        end else if (load) begin
            for (int i = 0; i < MAX_BYTES; i++)
                lane[i] <= load_bytes[(MAX_BYTES-1-i)*BYTE_W +: BYTE_W];
            cnt    <= load_n;
            last_q <= load_last && (load_n != '0);
        end else if (pop) begin
            for (int i = 0; i < MAX_BYTES; i++) lane[i] <= lane_shift[i];
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) last_q <= 1'b0;
        end
    end

    assign out_valid = (cnt != '0);
    assign out_byte  = lane[0];
    assign out_last  = last_q && (cnt == CNT_W'(1));
    assign empty     = (cnt == '0);
endmodule

// File: rtl/pix_wire_packer.sv
// Module: top of the serial display pixel packer.
// Assumes: the selects are settled one cycle before a burst; one pixel is in flight at a time.
module pix_wire_packer
    import pwp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FMT_W-1:0]    fmt_sel,
    input  logic                bgr_sel,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [PIX_W-1:0]    in_pix,
    input  logic                in_last,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [BYTE_W-1:0]   out_byte,
    output logic                out_last
);
    logic                        accept;
    logic                        q_empty;
    logic [FMT_W-1:0]            cfg_fmt;
    logic                        cfg_bgr;
    logic                        burst_active;
    logic [MAX_BYTES*BYTE_W-1:0] fmt_bytes;
    logic [CNT_W-1:0]            fmt_n;

    assign in_ready = q_empty;
    assign accept   = in_valid && in_ready;

    pwp_cfg_hold u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .fmt_sel      (fmt_sel),
        .bgr_sel      (bgr_sel),
        .accept       (accept),
        .accept_last  (in_last),
        .cfg_fmt      (cfg_fmt),
        .cfg_bgr      (cfg_bgr),
        .burst_active (burst_active)
    );

    pwp_pixel_format u_fmt (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .pix    (in_pix),
        .last   (in_last),
        .fmt    (cfg_fmt),
        .bgr    (cfg_bgr),
        .bytes  (fmt_bytes),
        .nbytes (fmt_n)
    );

    pwp_byte_queue u_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_bytes (fmt_bytes),
        .load_n     (fmt_n),
        .load_last  (in_last),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_byte   (out_byte),
        .out_last   (out_last),
        .empty      (q_empty)
    );
endmodule

// File: rtl/pwp_checker.sv
// Module: protocol and configuration properties of the pixel packer, bound to the top.
module pwp_checker
    import pwp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_last,
    input logic              in_burst,
    input logic [FMT_W-1:0]  cfg_fmt,
    input logic              cfg_bgr
);
    a_r10_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        in_burst |=> ($stable(cfg_fmt) && $stable(cfg_bgr)));

    a_r11_last_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    a_r11_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

bind pix_wire_packer pwp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_last  (out_last),
    .in_burst  (burst_active),
    .cfg_fmt   (cfg_fmt),
    .cfg_bgr   (cfg_bgr)
);

// File: tb/pix_wire_packer_tb.sv
// Directed bench for the pixel packer: one task per scenario, each checking its own bytes.
module pix_wire_packer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt_sel = 3'd0;
    logic        bgr_sel = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_pix = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_byte;
    logic        out_last;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  got_q[$];
    bit          got_last_q[$];
    logic [7:0]  exp_q[$];
    logic [23:0] pbuf[8];
    int          pn;
    bit          block_ready = 1'b0;
    bit          stall = 1'b0;
    logic [7:0]  lfsr = 8'hA5;

    always #5 clk = ~clk;

    pix_wire_packer u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bgr_sel(bgr_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .out_last(out_last)
    );

    // out_ready changes only at the rising edge so it is settled at the sampling edge
    always @(posedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= block_ready ? 1'b0 : (stall ? lfsr[0] : 1'b1);
    end

    // byte monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            got_q.push_back(out_byte);
            got_last_q.push_back(out_last);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] tri3(input logic [23:0] p, input bit bgr);
        return bgr ? {p[7], p[15], p[23]} : {p[23], p[15], p[7]};
    endfunction

    function automatic logic [7:0] tri_pair(input logic [2:0] fmt, input logic [2:0] a, input logic [2:0] b);
        return (fmt == 3'd4) ? {1'b0, a, 1'b0, b} : {2'b00, a, b};
    endfunction

    // expected wire bytes for pbuf[0..pn-1], written from the requirements
    task automatic build_expected(input logic [2:0] fmt, input bit bgr);
        exp_q.delete();
        for (int i = 0; i < pn; i++) begin
            logic [7:0] r, g, b, c0, c2;
            logic [15:0] w;
            r = pbuf[i][23:16]; g = pbuf[i][15:8]; b = pbuf[i][7:0];
            c0 = bgr ? b : r;
            c2 = bgr ? r : b;
            case (fmt)
                3'd1: begin
                    exp_q.push_back({c0[7:2], 2'b00});
                    exp_q.push_back({g[7:2], 2'b00});
                    exp_q.push_back({c2[7:2], 2'b00});
                end
                3'd2: begin
                    exp_q.push_back(c0); exp_q.push_back(g); exp_q.push_back(c2);
                end
                3'd3, 3'd4: begin
                    if (i % 2 == 1)
                        exp_q.push_back(tri_pair(fmt, tri3(pbuf[i-1], bgr), tri3(pbuf[i], bgr)));
                    else if (i == pn - 1)
                        exp_q.push_back(tri_pair(fmt, tri3(pbuf[i], bgr), 3'b000));
                end
                default: begin
                    w = {c0[7:3], g[7:2], c2[7:3]};
                    exp_q.push_back(w[15:8]);
                    exp_q.push_back(w[7:0]);
                end
            endcase
        end
    endtask

    // offer one pixel from the current falling edge until it is taken
    task automatic push_pix(input logic [23:0] p, input bit last);
        bit taken;
        in_valid = 1'b1; in_pix = p; in_last = last;
        taken = 1'b0;
        while (!taken) begin
            taken = in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic drain_and_compare(input string req);
        int guard = 0;
        while (got_q.size() < exp_q.size() && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            chk(got_q[i] === exp_q[i], req, got_q[i], exp_q[i]);
            // R11: end marker only on the final byte
            chk(got_last_q[i] == (i == exp_q.size() - 1), {req, " R11"}, got_last_q[i], (i == exp_q.size() - 1));
        end
        got_q.delete();
        got_last_q.delete();
    endtask

    task automatic run_burst(input logic [2:0] fmt, input bit bgr, input string req);
        fmt_sel = fmt; bgr_sel = bgr;
        @(negedge clk);
        build_expected(fmt, bgr);
        for (int i = 0; i < pn; i++) push_pix(pbuf[i], i == pn - 1);
        drain_and_compare(req);
    endtask

    task automatic t_reset_default();
        rst_n = 1'b0; fmt_sel = 3'd1; bgr_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
        pn = 1; pbuf[0] = 24'hF0A53C;
        build_expected(3'd0, 1'b0);
        rst_n = 1'b1;
        push_pix(pbuf[0], 1'b1);
        drain_and_compare("R1 default 565");
    endtask

    task automatic t_565();
        pn = 3; pbuf[0] = 24'hF0A53C; pbuf[1] = 24'h123456; pbuf[2] = 24'hFFFFFF;
        run_burst(3'd0, 1'b0, "R2 565 rgb");
        run_burst(3'd0, 1'b1, "R4 565 bgr");
        pn = 2; pbuf[0] = 24'h80017F; pbuf[1] = 24'h000000;
        run_burst(3'd7, 1'b0, "R2 code7 as 565");
    endtask

    task automatic t_666();
        pn = 2; pbuf[0] = 24'hFF03C7; pbuf[1] = 24'h5A5A5A;
        run_burst(3'd1, 1'b0, "R3 666 rgb");
        run_burst(3'd1, 1'b1, "R4 666 bgr");
    endtask

    task automatic t_888();
        pn = 2; pbuf[0] = 24'h11AA37; pbuf[1] = 24'hC30F81;
        run_burst(3'd2, 1'b1, "R8 888 bgr");
        run_burst(3'd2, 1'b0, "R8 888 rgb");
    endtask

    task automatic t_tri();
        pn = 4; pbuf[0] = 24'h800000; pbuf[1] = 24'h008000; pbuf[2] = 24'h000080; pbuf[3] = 24'h80FF7F;
        run_burst(3'd3, 1'b0, "R5 packed rgb");
        run_burst(3'd3, 1'b1, "R4 packed bgr");
        run_burst(3'd4, 1'b0, "R6 nibble rgb");
        pn = 3;
        run_burst(3'd3, 1'b0, "R7 packed odd pad");
        run_burst(3'd4, 1'b1, "R7 nibble odd pad");
        pn = 1; pbuf[0] = 24'hFFFFFF;
        run_burst(3'd4, 1'b0, "R7 single pixel pad");
    endtask

    task automatic t_cfg_midburst();
        // 3-bit burst with a parked half byte when the selects change
        fmt_sel = 3'd3; bgr_sel = 1'b0;
        @(negedge clk);
        pn = 3; pbuf[0] = 24'h80FF00; pbuf[1] = 24'h0000FF; pbuf[2] = 24'hFF0000;
        build_expected(3'd3, 1'b0);
        push_pix(pbuf[0], 1'b0);
        fmt_sel = 3'd1; bgr_sel = 1'b1;
        repeat (2) @(negedge clk);
        push_pix(pbuf[1], 1'b0);
        push_pix(pbuf[2], 1'b1);
        drain_and_compare("R9 selects frozen in burst");
        pn = 1; pbuf[0] = 24'hFC0480;
        run_burst(3'd0, 1'b0, "R9 new burst uses new selects");
    endtask

    task automatic t_backpressure();
        fmt_sel = 3'd1; bgr_sel = 1'b0;
        block_ready = 1'b1;
        repeat (2) @(negedge clk);
        pn = 1; pbuf[0] = 24'hA4B8CC;
        build_expected(3'd1, 1'b0);
        push_pix(pbuf[0], 1'b1);
        for (int k = 0; k < 4; k++) begin
            chk(out_valid == 1'b1, "R10 held valid", out_valid, 1);
            chk(in_ready == 1'b0, "R10 in_ready low while pending", in_ready, 0);
            chk(out_byte == exp_q[0], "R10 held byte stable", out_byte, exp_q[0]);
            @(negedge clk);
        end
        block_ready = 1'b0;
        drain_and_compare("R10 after release");
        stall = 1'b1;
        pn = 6;
        for (int i = 0; i < 6; i++) pbuf[i] = 24'h3C1F07 * (i + 3);
        run_burst(3'd1, 1'b1, "R10 random stall 666");
        run_burst(3'd4, 1'b0, "R10 random stall nibble");
        stall = 1'b0;
    endtask

    initial begin
        t_reset_default();
        t_565();
        t_666();
        t_888();
        t_tri();
        t_cfg_midburst();
        t_backpressure();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule